// File: doc/BRIEF.md
# Mode-Banked Register File with Packed PC and Status Word

This block is the register storage for a small pipelined processor core. It holds sixteen 32-bit architectural registers. Register 15 packs the word program counter together with the condition flags, the two interrupt masks and a 2-bit processor mode. Registers 0 to 9 are a single set seen by every mode. Registers 10 to 14 exist once per mode, and the current mode picks which copy an access reaches.

The block has two combinational read ports: an operand-A port and an operand-B port. It also has one clocked write port and a separate status write-back path used by compare-style instructions that store their flag result into register 15. Because the mode is a field of register 15, any write to register 15 can change the mode. The banked mapping follows the mode one cycle late: the mapping register copies the mode field on the edge after register 15 changes. The instruction issued right after a mode change therefore still reaches the old bank.

Top module: `bankedRegFile`

## Requirements
- R1: Addresses 0 to 9 select one shared set of registers: a value written in any mode reads back unchanged in every mode.
- R2: Addresses 10 to 14 select a separate 5-register bank for each mode. The bank is chosen by the mapping mode, with encoding 0 = user, 1 = fast interrupt, 2 = interrupt, 3 = supervisor. A value written in one mode is not visible in another mode.
- R3: Register 15 has this layout: bits 31:26 are the flags N, Z, C, V, I, F (in that order, from bit 31 down), bits 25:2 are the word PC, and bits 1:0 are the mode. The operand-B port returns all 32 bits of it.
- R4: Reading register 15 through the operand-A port returns the PC in bits 25:2 and zero in bits 31:26 and 1:0.
- R5: A status write-back (`psrWrEn`) copies bits 31:26 and 1:0 of `psrData` into register 15 and leaves the PC unchanged.
- R6: The mapping mode (`modeOut`) takes the value of register 15's mode field one clock edge after that field changes. Reads and writes of addresses 10 to 14 use the mapping mode.
- R7: While register 15's mode field is user, any write to register 15 changes only flags N, Z, C, V among the status bits. I, F and the mode keep their values.
- R8: When the status write-back and a general write to register 15 happen in the same cycle, the PC comes from `wrData` and the status bits come from `psrData`. A general write to addresses 10 to 14 in the same cycle as a mode change goes to the bank of the old mapping mode.
- R9: After reset, registers 0 to 14 of every bank read zero, register 15 reads 0x0C000003 (I and F set, supervisor mode), and `modeOut` is 3.
- R10: For any address 0 to 14, both read ports return the same value in the same cycle.
- R11: A general write to register 15 loads the PC from `wrData[25:2]` and the status bits from `wrData` (subject to R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rnAddr | input | 4 | Operand-A read address |
| rnData | output | 32 | Operand-A read data; status bits of register 15 forced to zero |
| rmAddr | input | 4 | Operand-B read address |
| rmData | output | 32 | Operand-B read data; register 15 returned in full |
| wrEn | input | 1 | General write enable |
| wrAddr | input | 4 | General write address |
| wrData | input | 32 | General write data |
| psrWrEn | input | 1 | Status write-back enable |
| psrData | input | 32 | Status write-back source word |
| modeOut | output | 2 | Mapping mode currently used for registers 10 to 14 |

## Verification
Two functions can land on the same clock edge. The first case is a status write-back that changes the mode while the general port writes register 15. The second is a mode change while the general port writes a banked register. The bench drives both cases in directed steps, and they also occur in a long pseudo-random run. A behavioural model written in the bench is updated from the pre-edge state only, so the PC must come from the general data, the status must come from the write-back data, and the banked write must land in the old bank. The two later reads of the banked register, first in the old mode and then in the new one, decide whether the block behaved correctly.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 4;
  localparam int NUM_SHARED = 10;
  localparam int NUM_BANKED = 5;
  localparam int NUM_MODES  = 4;
  localparam int MODE_W     = $clog2(NUM_MODES);
  localparam int FLAG_W     = 6;
  localparam int PC_LSB     = MODE_W;
  localparam int PC_W       = DATA_W - FLAG_W - MODE_W;
  localparam int STATUS_W   = FLAG_W + MODE_W;
  localparam int BANK_IDX_W = $clog2(NUM_BANKED);
  localparam int PC_REG     = NUM_SHARED + NUM_BANKED;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 2'd0,
    MODE_FIQ = 2'd1,
    MODE_IRQ = 2'd2,
    MODE_SVC = 2'd3
  } mode_e;

  // status vector order: {N,Z,C,V,I,F,mode}
  localparam logic [DATA_W-1:0] PCREG_RESET = 32'h0C00_0003;

  typedef struct packed {
    logic                sharedWe;
    logic                bankWe;
    logic                pcWe;
    logic                statusWe;
    logic [STATUS_W-1:0] nextStatus;
  } rfStrobes_t;
endpackage

// File: rtl/rfControl.sv
module rfControl
  import rf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              psrWrEn,
  input  logic [DATA_W-1:0] psrData,
  input  logic [DATA_W-1:0] pcRegWord,
  output rfStrobes_t        strobes,
  output logic [MODE_W-1:0] effMode
);
  logic                pcHit;
  logic [DATA_W-1:0]   srcWord;
  logic [STATUS_W-1:0] reqStatus;
  logic [STATUS_W-1:0] curStatus;
  logic                inUser;

  always_comb begin
    pcHit     = wrEn && (wrAddr == ADDR_W'(PC_REG));
    srcWord   = psrWrEn ? psrData : wrData;
    reqStatus = {srcWord[DATA_W-1 -: FLAG_W], srcWord[MODE_W-1:0]};
    curStatus = {pcRegWord[DATA_W-1 -: FLAG_W], pcRegWord[MODE_W-1:0]};
    inUser    = (pcRegWord[MODE_W-1:0] == MODE_USR);

    strobes.sharedWe = wrEn && (wrAddr < ADDR_W'(NUM_SHARED));
    strobes.bankWe   = wrEn && (wrAddr >= ADDR_W'(NUM_SHARED))
                            && (wrAddr < ADDR_W'(PC_REG));
    strobes.pcWe     = pcHit;
    strobes.statusWe = pcHit || psrWrEn;
    if (inUser)
      strobes.nextStatus = {reqStatus[STATUS_W-1 -: 4], curStatus[STATUS_W-5:0]};
    else
      strobes.nextStatus = reqStatus;
  end

  // mapping mode trails the stored mode field by one edge
  always_ff @(posedge clk) begin
    if (!rstN) effMode <= MODE_SVC;
    else       effMode <= pcRegWord[MODE_W-1:0];
  end
endmodule

// File: rtl/rfDatapath.sv
module rfDatapath
  import rf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobes_t        strobes,
  input  logic [MODE_W-1:0] effMode,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rnAddr,
  input  logic [ADDR_W-1:0] rmAddr,
  output logic [DATA_W-1:0] rnData,
  output logic [DATA_W-1:0] rmData,
  output logic [DATA_W-1:0] pcRegWord
);
  localparam logic [DATA_W-1:0] PC_MASK = {{FLAG_W{1'b0}}, {PC_W{1'b1}}, {MODE_W{1'b0}}};

  logic [DATA_W-1:0]     sharedQ [NUM_SHARED];
  logic [DATA_W-1:0]     pcRegQ;
  logic [DATA_W-1:0]     rnView  [NUM_MODES];
  logic [DATA_W-1:0]     rmView  [NUM_MODES];
  logic [BANK_IDX_W-1:0] wrIdx, rnIdx, rmIdx;

  assign wrIdx = BANK_IDX_W'(wrAddr - ADDR_W'(NUM_SHARED));
  assign rnIdx = BANK_IDX_W'(rnAddr - ADDR_W'(NUM_SHARED));
  assign rmIdx = BANK_IDX_W'(rmAddr - ADDR_W'(NUM_SHARED));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_SHARED; k++) sharedQ[k] <= '0;
    end else if (strobes.sharedWe) begin
      sharedQ[wrAddr] <= wrData;
    end
  end

  genvar m;
  for (m = 0; m < NUM_MODES; m++) begin : g_bank
    logic [DATA_W-1:0] regs [NUM_BANKED];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int k = 0; k < NUM_BANKED; k++) regs[k] <= '0;
      end else if (strobes.bankWe && (effMode == MODE_W'(m))) begin
        regs[wrIdx] <= wrData;
      end
    end
    assign rnView[m] = regs[rnIdx];
    assign rmView[m] = regs[rmIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcRegQ <= PCREG_RESET;
    end else begin
      if (strobes.pcWe)
        pcRegQ[PC_LSB +: PC_W] <= wrData[PC_LSB +: PC_W];
      if (strobes.statusWe) begin
        pcRegQ[DATA_W-1 -: FLAG_W] <= strobes.nextStatus[STATUS_W-1 -: FLAG_W];
        pcRegQ[MODE_W-1:0]         <= strobes.nextStatus[MODE_W-1:0];
      end
    end
  end

  always_comb begin
    if (rnAddr < ADDR_W'(NUM_SHARED))  rnData = sharedQ[rnAddr];
    else if (rnAddr < ADDR_W'(PC_REG)) rnData = rnView[effMode];
    else                               rnData = pcRegQ & PC_MASK;

    if (rmAddr < ADDR_W'(NUM_SHARED))  rmData = sharedQ[rmAddr];
    else if (rmAddr < ADDR_W'(PC_REG)) rmData = rmView[effMode];
    else                               rmData = pcRegQ;
  end

  assign pcRegWord = pcRegQ;
endmodule

// File: rtl/bankedRegFile.sv
module bankedRegFile
  import rf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rnAddr,
  output logic [DATA_W-1:0] rnData,
  input  logic [ADDR_W-1:0] rmAddr,
  output logic [DATA_W-1:0] rmData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              psrWrEn,
  input  logic [DATA_W-1:0] psrData,
  output logic [MODE_W-1:0] modeOut
);
  rfStrobes_t        strobes;
  logic [DATA_W-1:0] pcRegWord;
  logic [MODE_W-1:0] effMode;

  rfControl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .psrWrEn(psrWrEn), .psrData(psrData), .pcRegWord(pcRegWord),
    .strobes(strobes), .effMode(effMode)
  );

  rfDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .effMode(effMode),
    .wrAddr(wrAddr), .wrData(wrData), .rnAddr(rnAddr), .rmAddr(rmAddr),
    .rnData(rnData), .rmData(rmData), .pcRegWord(pcRegWord)
  );

  assign modeOut = effMode;
endmodule

// File: rtl/rfChecker.sv
module rfChecker
  import rf_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] rnAddr,
  input logic [DATA_W-1:0] rnData,
  input logic [ADDR_W-1:0] rmAddr,
  input logic [DATA_W-1:0] rmData,
  input logic [MODE_W-1:0] modeOut,
  input logic [DATA_W-1:0] pcRegWord
);
  AST_RN_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rnAddr == ADDR_W'(PC_REG)) |-> (rnData[DATA_W-1 -: FLAG_W] == '0 && rnData[MODE_W-1:0] == '0)); // R4
  AST_RN_PC_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (rnAddr == ADDR_W'(PC_REG) && rmAddr == ADDR_W'(PC_REG)) |-> (rnData[PC_LSB +: PC_W] == rmData[PC_LSB +: PC_W])); // R4
  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    (rnAddr == rmAddr && rnAddr != ADDR_W'(PC_REG)) |-> (rnData == rmData)); // R10
  AST_MAP_LAG: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (modeOut == $past(pcRegWord[MODE_W-1:0]))); // R6
  AST_USER_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (pcRegWord[MODE_W-1:0] == MODE_USR) |=> (pcRegWord[MODE_W-1:0] == MODE_USR && $stable(pcRegWord[27:26]))); // R7
  AST_RESET_STATE: assert property (@(posedge clk)
    $rose(rstN) |-> (modeOut == MODE_SVC && pcRegWord == PCREG_RESET)); // R9
endmodule

bind bankedRegFile rfChecker u_chk (
  .clk(clk), .rstN(rstN), .rnAddr(rnAddr), .rnData(rnData), .rmAddr(rmAddr),
  .rmData(rmData), .modeOut(modeOut), .pcRegWord(pcRegWord)
);

// File: tb/bankedRegFile_bench.sv
`timescale 1ns/1ps
module bankedRegFile_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rnAddr = '0, rmAddr = '0, wrAddr = '0;
  logic [31:0] rnData, rmData, wrData = '0, psrData = '0;
  logic        wrEn = 1'b0, psrWrEn = 1'b0;
  logic [1:0]  modeOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mShared [10];
  logic [31:0] mBank [4][5];
  logic [31:0] mPc;
  logic [1:0]  mMap;

  always #2 clk = ~clk;

  bankedRegFile u_bankedRegFile (
    .clk(clk), .rstN(rstN), .rnAddr(rnAddr), .rnData(rnData), .rmAddr(rmAddr),
    .rmData(rmData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .psrWrEn(psrWrEn), .psrData(psrData), .modeOut(modeOut)
  );

  function automatic logic [31:0] modelRead(input logic [3:0] a, input bit full);
    if (a < 10)      return mShared[a];
    else if (a < 15) return mBank[mMap][a-10];
    else if (full)   return mPc;
    else             return mPc & 32'h03FF_FFFC;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 10; i++) mShared[i] = '0;
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 5; k++) mBank[m][k] = '0;
    mPc  = 32'h0C00_0003;
    mMap = 2'd3;
  endtask

  task automatic modelEdge(input bit we, input logic [3:0] wa, input logic [31:0] wd,
                           input bit pe, input logic [31:0] pd);
    logic [31:0] nxt;
    logic [31:0] src;
    logic [1:0]  oldMode;
    oldMode = mPc[1:0];
    if (we && wa < 10)      mShared[wa] = wd;
    else if (we && wa < 15) mBank[mMap][wa-10] = wd;
    nxt = mPc;
    if (we && wa == 15) nxt[25:2] = wd[25:2];
    if (pe || (we && wa == 15)) begin
      src = pe ? pd : wd;
      if (oldMode == 2'd0) nxt[31:28] = src[31:28];
      else begin
        nxt[31:26] = src[31:26];
        nxt[1:0]   = src[1:0];
      end
    end
    mPc  = nxt;
    mMap = oldMode;
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input bit we, input logic [3:0] wa,
                      input logic [31:0] wd, input bit pe, input logic [31:0] pd,
                      input logic [3:0] ra, input logic [3:0] rb);
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd; psrWrEn = pe; psrData = pd;
    rnAddr = ra; rmAddr = rb;
    #1;
    check(tag, "rnData", rnData, modelRead(ra, 1'b0));
    check(tag, "rmData", rmData, modelRead(rb, 1'b1));
    check("R6", "modeOut", {30'd0, modeOut}, {30'd0, mMap});
    @(posedge clk);
    modelEdge(we, wa, wd, pe, pd);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; psrWrEn = 1'b0;
    repeat (2) @(posedge clk);
    modelReset();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    modelReset();
    doReset();
    // R9 reset values, R4 masking of register 15 on operand A
    step("R9", 0, 0, 0, 0, 0, 15, 15);
    step("R9", 0, 0, 0, 0, 0, 12, 4);
    step("R4", 0, 0, 0, 0, 0, 15, 0);
    // R1 shared write in supervisor mode
    step("R1", 1, 3, 32'h1234_5678, 0, 0, 3, 3);
    // R2 banked write in supervisor mode
    step("R2", 1, 11, 32'h1111_1111, 0, 0, 3, 11);
    // R8 banked write on the same edge as a switch to fast-interrupt mode
    step("R8", 1, 12, 32'h2222_2222, 1, 32'hF000_0001, 11, 15);
    // R6 next step still maps the old bank; R5 status written, PC kept
    step("R6", 0, 0, 0, 0, 0, 11, 12);
    step("R5", 0, 0, 0, 0, 0, 15, 15);
    // R2 new bank is empty, shared value still visible (R1)
    step("R2", 0, 0, 0, 0, 0, 11, 12);
    step("R1", 0, 0, 0, 0, 0, 3, 3);
    // R11 general write to register 15: interrupt mode, I set, new PC
    step("R11", 1, 15, 32'h0800_0FFE, 0, 0, 15, 15);
    step("R11", 0, 0, 0, 0, 0, 15, 15);
    // R8 simultaneous general and status write to register 15
    step("R8", 1, 15, 32'h0000_0100, 1, 32'h4000_0003, 15, 15);
    step("R8", 0, 0, 0, 0, 0, 15, 15);
    // R5 status write-back into user mode
    step("R5", 0, 0, 0, 1, 32'h0000_0000, 15, 15);
    // R7 user mode cannot raise masks or leave user mode
    step("R7", 0, 0, 0, 1, 32'hFC00_0003, 15, 15);
    step("R7", 1, 15, 32'hFFFF_FFFF, 0, 0, 15, 15);
    step("R7", 0, 0, 0, 0, 0, 15, 15);
    // R10 both ports agree on banked and shared addresses
    step("R10", 1, 13, 32'hABCD_0013, 0, 0, 13, 13);
    step("R10", 0, 0, 0, 0, 0, 13, 13);
    step("R10", 0, 0, 0, 0, 0, 3, 3);
    step("R3", 0, 0, 0, 0, 0, 14, 15);

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] ra, rb, wa;
      string tg;
      if (i % 250 == 0) doReset();
      ra = 4'($urandom_range(0, 15));
      rb = 4'($urandom_range(0, 15));
      wa = 4'($urandom_range(0, 15));
      tg = (rb == 15) ? "R3" : (ra == 15) ? "R4" : (ra < 10) ? "R1" : "R2";
      step(tg, ($urandom_range(0, 3) != 0), wa, $urandom,
           ($urandom_range(0, 7) == 0), $urandom, ra, rb);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule